// File: doc/BRIEF.md
# Synchronous Burst Read Bus Controller

This block is the host side of a memory-controller bank that reads from a burst-capable flash. When a read request is accepted, it drives the request address and selects the device. It pulses the address-valid strobe low for one clock and then waits a set number of wait states. After that it captures one data beat on each clock until the burst is complete. The wait-state count is counted from the address cycle itself. It must therefore be programmed one higher than the flash's own initial-latency setting. For example, a flash set to a 4-clock delay needs 5 wait states here, which gives a 5-1-1-1 pattern for a four-beat burst.

With burst mode off, the controller does a single read using a long fixed wait count (15 by default). That count is safe for asynchronous reads, before the flash has been switched into its synchronous mode. With burst mode on, the wait count comes from the wait-state input, and the burst length is either 4 or 8 beats. Each captured beat is reported with a one-clock valid pulse. A done pulse marks the final beat.

Top module: `burst_rd_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_cs_n_o`, `mem_adv_n_o` and `mem_oe_n_o` are high and `beat_valid_o` and `done_o` are low.
- R2: In the cycle after a request is accepted (the address cycle), `mem_cs_n_o` and `mem_adv_n_o` are low. `mem_adv_n_o` is low for that one cycle only. `mem_addr_o` equals the requested address and holds it until the select is released.
- R3: In burst mode (`burst_en_i`=1) the total wait count W is `wait_i`, with values 0 and 1 treated as 2. The address cycle is cycle 1. The first beat is the bus value sampled at the end of cycle W, and `beat_valid_o` first rises in cycle W+1.
- R4: With `burst_en_i`=0 the access is a single read of exactly one beat. It uses W = DEF_WS (15) whatever `wait_i` and `burst8_i` hold.
- R5: A burst delivers 8 beats when `burst8_i`=1 and 4 beats when `burst8_i`=0, on consecutive clocks with no gap.
- R6: `beat_valid_o` is high for exactly one clock per beat, and `beat_data_o` then shows the bus value of the preceding clock. `done_o` is high only together with the final beat.
- R7: `mem_cs_n_o` is low from the address cycle through cycle W+L-1 (the last data cycle, L beats) and high in cycle W+L. `mem_oe_n_o` is low from cycle 2 through cycle W+L-1.
- R8: A request is taken only when no access is in progress, counting the release cycle W+L as free. A request raised during an access has no effect. A request held in the release cycle starts a new address cycle right after it, so the select is high for exactly one clock.
- R9: While `beat_valid_o` is low, `beat_data_o` keeps the last captured beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Read request, sampled on the rising edge |
| addr_i | input | ADDR_W | Start address of the read |
| burst_en_i | input | 1 | 1: burst read with `wait_i`; 0: single read with DEF_WS |
| wait_i | input | WS_W | Total wait states for burst reads, address cycle included |
| burst8_i | input | 1 | 1: 8-beat burst; 0: 4-beat burst |
| mem_data_i | input | DATA_W | Data bus from the flash |
| mem_cs_n_o | output | 1 | Device select, active low |
| mem_adv_n_o | output | 1 | Address-valid / transfer-start strobe, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_addr_o | output | ADDR_W | Address driven to the flash |
| beat_data_o | output | DATA_W | Last captured data beat |
| beat_valid_o | output | 1 | One-clock pulse per captured beat |
| done_o | output | 1 | Pulses with the final beat of an access |

## Verification
The embedded assertions check the following on every cycle:
- the address-valid strobe lasts one clock and is followed by output enable;
- every new select opens with that strobe;
- the address stays steady while the device is selected;
- the wait counter never passes its target;
- done only appears with a valid beat, and only after the select is released;
- the data output holds between beats.

Only the bench's scenarios can show the absolute timing. That covers the cycle of the first beat for a given wait count (including the clamp and the fixed default for single reads), the beat counts of 4, 8 and 1, and the capture of the right bus value in each beat. It also covers requests that are ignored mid-access and the back-to-back request taken in the release cycle.

// File: rtl/brc_pkg.sv
package brc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_WAIT,
      ST_BEAT,
      ST_GAP
   } brc_state_e;
endpackage

// File: rtl/brc_seq.sv
module brc_seq
   import brc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned WS_W      = 4,
   parameter int unsigned DEF_WS    = 15,
   parameter int unsigned SHORT_LEN = 4,
   parameter int unsigned LONG_LEN  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              burst_en_i,
   input  logic [WS_W-1:0]   wait_i,
   input  logic              burst8_i,
   output logic              cs_n_o,
   output logic              adv_n_o,
   output logic              oe_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              capture_o,
   output logic              last_o
);
   localparam int unsigned WS_FIELD_MAX = (1 << WS_W) - 1;
   localparam int unsigned MAX_WS = (WS_FIELD_MAX > DEF_WS) ? WS_FIELD_MAX : DEF_WS;
   localparam int unsigned CW = $clog2(MAX_WS + 1) + 1;
   localparam int unsigned LW = $clog2(LONG_LEN + 1);

   brc_state_e        state;
   logic [CW-1:0]     cyc;
   logic [CW-1:0]     cyc_nx;
   logic [CW-1:0]     ws_q;
   logic [CW-1:0]     ws_req;
   logic [LW-1:0]     len_q;
   logic [LW-1:0]     len_req;
   logic [LW-1:0]     bcnt;
   logic [ADDR_W-1:0] addr_q;
   logic              free;
   logic              accept;
   logic              final_beat;

   // request decode: clamp burst wait count, fixed count for single reads
   always_comb begin
      if (!burst_en_i) begin
         ws_req  = CW'(DEF_WS);
         len_req = LW'(1);
      end else begin
         ws_req  = (wait_i < WS_W'(2)) ? CW'(2) : CW'(wait_i);
         len_req = burst8_i ? LW'(LONG_LEN) : LW'(SHORT_LEN);
      end
   end

   assign free       = (state == ST_IDLE) || (state == ST_GAP);
   assign accept     = free && req_i;
   assign cyc_nx     = cyc + 1'b1;
   assign final_beat = (bcnt == len_q - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cyc    <= '0;
         ws_q   <= CW'(DEF_WS);
         len_q  <= LW'(1);
         bcnt   <= '0;
         addr_q <= '0;
      end else begin
         case (state)
            ST_ADDR, ST_WAIT: begin
               cyc <= cyc_nx;
               if (cyc_nx == ws_q) state <= ST_BEAT;
               else                state <= ST_WAIT;
            end
            ST_BEAT: begin
               if (final_beat) state <= ST_GAP;
               else            bcnt  <= bcnt + 1'b1;
            end
            default: begin
               if (accept) begin
                  state  <= ST_ADDR;
                  addr_q <= addr_i;
                  ws_q   <= ws_req;
                  len_q  <= len_req;
                  cyc    <= CW'(1);
                  bcnt   <= '0;
               end else begin
                  state <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign cs_n_o    = !((state == ST_ADDR) || (state == ST_WAIT) || (state == ST_BEAT));
   assign adv_n_o   = !(state == ST_ADDR);
   assign oe_n_o    = !((state == ST_WAIT) || (state == ST_BEAT));
   assign addr_o    = addr_q;
   assign capture_o = (state == ST_BEAT);
   assign last_o    = (state == ST_BEAT) && final_beat;

   AST_ADV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_n_o |=> adv_n_o); // R2
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && adv_n_o) |-> $stable(addr_o)); // R2
   AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> (cyc < ws_q)); // R3
   AST_OE_AFTER_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_n_o |=> !oe_n_o); // R7
   AST_SELECT_OPENS_WITH_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> !adv_n_o); // R8
endmodule

// File: rtl/brc_capture.sv
module brc_capture #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic              last_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              done_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_o  <= '0;
         valid_o <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         valid_o <= capture_i;
         done_o  <= capture_i && last_i;
         if (capture_i) data_o <= data_i;
      end
   end

   AST_DONE_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> valid_o); // R6
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> $stable(data_o)); // R9
endmodule

// File: rtl/burst_rd_ctrl.sv
module burst_rd_ctrl #(
   parameter int unsigned ADDR_W    = 20,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned WS_W      = 4,
   parameter int unsigned DEF_WS    = 15,
   parameter int unsigned SHORT_LEN = 4,
   parameter int unsigned LONG_LEN  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              burst_en_i,
   input  logic [WS_W-1:0]   wait_i,
   input  logic              burst8_i,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic              mem_cs_n_o,
   output logic              mem_adv_n_o,
   output logic              mem_oe_n_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] beat_data_o,
   output logic              beat_valid_o,
   output logic              done_o
);
   generate
      if (DEF_WS < 2) begin : g_bad_def_ws
         $error("DEF_WS must be at least 2");
      end
      if (WS_W < 2) begin : g_bad_ws_w
         $error("WS_W must be at least 2");
      end
      if ((SHORT_LEN < 1) || (LONG_LEN < SHORT_LEN)) begin : g_bad_len
         $error("burst lengths must satisfy 1 <= SHORT_LEN <= LONG_LEN");
      end
   endgenerate

   logic capture;
   logic last;

   brc_seq #(
      .ADDR_W    (ADDR_W),
      .WS_W      (WS_W),
      .DEF_WS    (DEF_WS),
      .SHORT_LEN (SHORT_LEN),
      .LONG_LEN  (LONG_LEN)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .addr_i     (addr_i),
      .burst_en_i (burst_en_i),
      .wait_i     (wait_i),
      .burst8_i   (burst8_i),
      .cs_n_o     (mem_cs_n_o),
      .adv_n_o    (mem_adv_n_o),
      .oe_n_o     (mem_oe_n_o),
      .addr_o     (mem_addr_o),
      .capture_o  (capture),
      .last_o     (last)
   );

   brc_capture #(
      .DATA_W (DATA_W)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .last_i    (last),
      .data_i    (mem_data_i),
      .data_o    (beat_data_o),
      .valid_o   (beat_valid_o),
      .done_o    (done_o)
   );

   AST_RELEASED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> mem_cs_n_o); // R7
   AST_VALID_NEEDS_PRIOR_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      beat_valid_o |-> !$past(mem_cs_n_o)); // R6
endmodule

// File: tb/tb_burst_rd_ctrl.sv
module tb_burst_rd_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [19:0] addr_i = '0;
   logic        burst_en_i = 1'b0;
   logic [3:0]  wait_i = '0;
   logic        burst8_i = 1'b0;
   logic [31:0] mem_data_i = '0;
   logic        mem_cs_n_o, mem_adv_n_o, mem_oe_n_o;
   logic [19:0] mem_addr_o;
   logic [31:0] beat_data_o;
   logic        beat_valid_o, done_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   burst_rd_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
      .burst_en_i(burst_en_i), .wait_i(wait_i), .burst8_i(burst8_i),
      .mem_data_i(mem_data_i), .mem_cs_n_o(mem_cs_n_o), .mem_adv_n_o(mem_adv_n_o),
      .mem_oe_n_o(mem_oe_n_o), .mem_addr_o(mem_addr_o), .beat_data_o(beat_data_o),
      .beat_valid_o(beat_valid_o), .done_o(done_o)
   );

   localparam int NV = 6;
   localparam logic [19:0] V_ADDR [NV] = '{20'h12345, 20'h0ABCD, 20'h00010, 20'hFFFFF, 20'h54321, 20'h7F00F};
   localparam logic        V_BEN  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
   localparam logic        V_B8   [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
   localparam logic [3:0]  V_WS   [NV] = '{4'd5, 4'd4, 4'd3, 4'd0, 4'd2, 4'd15};

   function automatic logic [31:0] pattern(input logic [19:0] a, input int k);
      return {4'h9, a, 8'(k)};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   logic [31:0] last_beat;

   task automatic run_access(input logic [19:0] a, input logic ben, input logic b8,
                             input logic [3:0] ws, input bit pre, input bit noise);
      int w, l, beats;
      w = ben ? ((ws < 2) ? 2 : int'(ws)) : 15;
      l = ben ? (b8 ? 8 : 4) : 1;
      beats = 0;
      if (!pre) @(negedge clk);
      req_i = 1'b1; addr_i = a; burst_en_i = ben; burst8_i = b8; wait_i = ws;
      @(posedge clk);
      for (int j = 1; j <= w + l; j++) begin
         @(negedge clk);
         if (j == 1) begin
            req_i = 1'b0;
            wait_i = ~ws; burst8_i = ~b8;
         end
         if (noise && j == 3) begin req_i = 1'b1; addr_i = ~a; end
         if (noise && j == 4) begin req_i = 1'b0; addr_i = a; end
         mem_data_i = (j >= w) ? pattern(a, j - w) : (32'hBAD0_0000 | 32'(j));
         chk("R7 cs_n", 32'(mem_cs_n_o), 32'(!(j <= w + l - 1)));
         chk((pre && j == 1) ? "R8 adv_n" : "R2 adv_n", 32'(mem_adv_n_o), 32'(!(j == 1)));
         chk("R7 oe_n", 32'(mem_oe_n_o), 32'(!(j >= 2 && j <= w + l - 1)));
         if (j <= w + l - 1) chk("R2 addr", 32'(mem_addr_o), 32'(a));
         chk(!ben ? "R4 valid" : (j == w + 1 ? "R3 valid" : "R6 valid"),
             32'(beat_valid_o), 32'(j >= w + 1 && j <= w + l));
         chk("R6 done", 32'(done_o), 32'(j == w + l));
         if (beat_valid_o) begin
            beats++;
            chk("R6 data", beat_data_o, pattern(a, j - w - 1));
         end
      end
      chk(ben ? "R5 beat count" : "R4 beat count", 32'(beats), 32'(l));
      last_beat = pattern(a, l - 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 cs_n", 32'(mem_cs_n_o), 32'd1);
      chk("R1 adv_n", 32'(mem_adv_n_o), 32'd1);
      chk("R1 oe_n", 32'(mem_oe_n_o), 32'd1);
      chk("R1 valid", 32'(beat_valid_o), 32'd0);
      chk("R1 done", 32'(done_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 cs_n after", 32'(mem_cs_n_o), 32'd1);
      chk("R1 valid after", 32'(beat_valid_o), 32'd0);

      // vector table: wait counts, clamp, single default, both lengths
      for (int v = 0; v < NV; v++) begin
         run_access(V_ADDR[v], V_BEN[v], V_B8[v], V_WS[v], 1'b0, 1'b0);
         @(negedge clk);
         chk("R9 hold", beat_data_o, last_beat);
      end

      // R4: single read ignores tiny wait_i and burst8_i
      run_access(20'h0C0DE, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0);

      // R8: back-to-back request in the release cycle
      run_access(20'h11111, 1'b1, 1'b0, 4'd3, 1'b0, 1'b0);
      run_access(20'h22222, 1'b1, 1'b1, 4'd4, 1'b1, 1'b0);

      // R8: request raised during an access is ignored
      run_access(20'h33333, 1'b1, 1'b0, 4'd5, 1'b0, 1'b1);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R8 no spurious select", 32'(mem_cs_n_o), 32'd1);
         chk("R9 data held", beat_data_o, last_beat);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule